// File: doc/BRIEF.md
# SPI Configuration Register Slave

This block is a three-wire serial slave that lets a host read and write a small byte-wide configuration register file. The host lowers chip select and clocks in a 16-bit instruction that names the direction, how many data bytes follow and the starting register address. The data bytes then move over one shared data line: into the block on a write, out of it on a read. The block runs entirely in the system clock domain. It synchronizes the serial pins and acts on rising serial-clock edges.

Multi-byte and open-ended (streaming) transfers step the register address after every byte. The step is downward in MSB-first order and upward in LSB-first order. A configuration register selects the bit order and can trigger a soft reset of the rest of the register file. A channel-index register picks which copy of the per-channel registers receives writes: channel A, channel B or both. The pad tristate buffer is outside the block; an output-enable signal marks the cycles in which the block drives the data line.

Top module: `spi_cfg_slave`

## Requirements
- R1: After `rst`, `spi_sdo_oe` is low, register 0x00 reads 0x00, register 0x05 reads 0x00 and the general registers 0x08..0x0F and per-channel registers 0x10..0x13 read 0x00.
- R2: The instruction is 16 bits. In MSB-first order (the order after reset) it arrives as the direction flag (1 = read), then the length code's high and low bits, then address bits 12 down to 0. Bits are sampled on rising `spi_sclk` while `spi_csb` is low.
- R3: Length code 00, 01 and 10 transfer exactly 1, 2 and 3 data bytes. Further clock edges before `spi_csb` rises change no register.
- R4: Length code 11 streams bytes until `spi_csb` rises. In MSB-first order the address decreases by one after each byte.
- R5: Writing register 0x00 with bit 6 or bit 1 set selects LSB-first order from the next frame on. In that order the whole 16-bit instruction and every data byte arrive least significant bit first, and the address increases after each byte. Register 0x00 reads back the order flag in both bit 6 and bit 1.
- R6: Writing register 0x00 with bit 5 or bit 2 set returns every register except 0x00, 0x09 and 0x0A to its reset value. Bits 5 and 2 always read back 0.
- R7: Register 0x01 always reads 0x22 and ignores writes. Unmapped addresses read 0x00 and ignore writes.
- R8: Register 0x05 (bits 1:0) routes writes to registers 0x10..0x13. Value 1 writes channel A only, 2 writes channel B only, and 0 or 3 write both. Reads return the channel B copy when the value is 2 and the channel A copy otherwise.
- R9: Raising `spi_csb` between data bytes of a length-coded transfer pauses it. A byte cut short by `spi_csb` rising is discarded. When `spi_csb` falls again the transfer resumes at the same byte and address.
- R10: Raising `spi_csb` before the 16th instruction bit abandons the frame without changing any register, and the next falling `spi_csb` starts a new instruction.
- R11: During the data phase of a read with `spi_csb` low, `spi_sdo_oe` is high and `spi_sdo` presents each register byte in the frame's bit order, one bit per rising edge. `spi_sdo_oe` stays low during write frames and drops after `spi_csb` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csb | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Data line as seen from the pad (host to block) |
| spi_sdo | output | 1 | Data the block drives onto the line during reads |
| spi_sdo_oe | output | 1 | High while the block drives the data line |

## Verification
The assertions assume that the serial pins are slow relative to `clk`: each `spi_sclk` level lasts several system clocks, chip select and data change only while `spi_sclk` is low, and chip select never rises at the exact moment a read instruction completes. The stimulus holds each serial-clock phase for eight system clocks. It moves `spi_sdi` and `spi_csb` on the falling system-clock edge while `spi_sclk` is low, so every bit crosses the synchronizer well before the edge that samples it.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  typedef enum logic [1:0] {
    ST_INSTR = 2'd0,
    ST_DATA  = 2'd1,
    ST_DONE  = 2'd2
  } frame_st_e;

  // length code that keeps the frame open until chip select rises
  localparam logic [1:0] LEN_STREAM = 2'b11;

  // bit positions inside the control register (decoded by the register bank)
  localparam int CFG_ORDER_HI = 6;
  localparam int CFG_ORDER_LO = 1;
  localparam int CFG_SRST_HI  = 5;
  localparam int CFG_SRST_LO  = 2;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic csb_in,
  input  logic sdi_in,
  output logic sclk_rise,
  output logic cs_act,
  output logic sdi_s
);
  logic [STAGES-1:0] sclk_sr, csb_sr, sdi_sr;
  logic              sclk_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sr   <= '0;
      csb_sr    <= '1;
      sdi_sr    <= '0;
      sclk_last <= 1'b0;
    end else begin
      sclk_sr   <= {sclk_sr[STAGES-2:0], sclk_in};
      csb_sr    <= {csb_sr[STAGES-2:0], csb_in};
      sdi_sr    <= {sdi_sr[STAGES-2:0], sdi_in};
      sclk_last <= sclk_sr[STAGES-1];
    end
  end

  assign sclk_rise = sclk_sr[STAGES-1] & ~sclk_last;
  assign cs_act    = ~csb_sr[STAGES-1];
  assign sdi_s     = sdi_sr[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              cs_act,
  input  logic              sdi,
  input  logic              lsb_cfg,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int INSTR_W = ADDR_W + 3;
  localparam int CW      = $clog2(INSTR_W);

  frame_st_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic [INSTR_W-1:0] sr_q, sr_nxt;
  logic              ord_q, ord, rd_q, stream_q;
  logic [1:0]        left_q;
  logic [ADDR_W-1:0] addr_q, addr_step, ins_addr;
  logic [DATA_W-1:0] tx_q, rx_byte;
  logic              ins_rd;
  logic [1:0]        ins_len;
  logic              last_ins, last_byte;

  // order is sampled from the control register when a frame begins
  assign ord       = (st_q == ST_INSTR && cnt_q == '0) ? lsb_cfg : ord_q;
  assign sr_nxt    = ord ? {sdi, sr_q[INSTR_W-1:1]} : {sr_q[INSTR_W-2:0], sdi};
  assign rx_byte   = ord ? sr_nxt[INSTR_W-1 -: DATA_W] : sr_nxt[DATA_W-1:0];
  assign ins_rd    = sr_nxt[INSTR_W-1];
  assign ins_len   = sr_nxt[INSTR_W-2 -: 2];
  assign ins_addr  = sr_nxt[ADDR_W-1:0];
  assign addr_step = ord_q ? addr_q + 1'b1 : addr_q - 1'b1;
  assign rd_addr   = (st_q == ST_INSTR) ? ins_addr : addr_step;
  assign last_ins  = (cnt_q == CW'(INSTR_W-1));
  assign last_byte = (cnt_q == CW'(DATA_W-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_INSTR;
      cnt_q    <= '0;
      sr_q     <= '0;
      ord_q    <= 1'b0;
      rd_q     <= 1'b0;
      stream_q <= 1'b0;
      left_q   <= '0;
      addr_q   <= '0;
      tx_q     <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (st_q == ST_INSTR && cnt_q == '0) ord_q <= lsb_cfg;
      if (!cs_act) begin
        cnt_q <= '0;
        if (st_q == ST_DONE || (st_q == ST_DATA && stream_q)) st_q <= ST_INSTR;
      end else if (sclk_rise) begin
        sr_q  <= sr_nxt;
        cnt_q <= cnt_q + 1'b1;
        case (st_q)
          ST_INSTR: if (last_ins) begin
            st_q     <= ST_DATA;
            cnt_q    <= '0;
            rd_q     <= ins_rd;
            stream_q <= (ins_len == LEN_STREAM);
            left_q   <= ins_len;
            addr_q   <= ins_addr;
            tx_q     <= rd_data;
          end
          ST_DATA: if (last_byte) begin
            cnt_q <= '0;
            if (!rd_q) begin
              wr_en   <= 1'b1;
              wr_addr <= addr_q;
              wr_data <= rx_byte;
            end
            addr_q <= addr_step;
            tx_q   <= rd_data;
            if (!stream_q) begin
              if (left_q == 2'd0) st_q <= ST_DONE;
              else                left_q <= left_q - 2'd1;
            end
          end else begin
            tx_q <= ord_q ? (tx_q >> 1) : (tx_q << 1);
          end
          default: cnt_q <= '0;
        endcase
      end
      sdo    <= ord_q ? tx_q[0] : tx_q[DATA_W-1];
      sdo_oe <= cs_act && (st_q == ST_DATA) && rd_q;
    end
  end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_cfg_pkg::*;
#(
  parameter int          ADDR_W   = 13,
  parameter int          DATA_W   = 8,
  parameter int          GEN_BASE = 8,
  parameter int          NGEN     = 8,
  parameter int          CH_BASE  = 16,
  parameter int          NCHR     = 4,
  parameter logic [7:0]  CHIP_ID  = 8'h22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              lsb_first
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CHAN = ADDR_W'(5);
  localparam int NCH = 2;

  logic              cfg_wr, soft_rst;
  logic [1:0]        chan_q;
  logic [DATA_W-1:0] gen_rd [NGEN];
  logic [DATA_W-1:0] ch_rd  [NCH][NCHR];

  assign cfg_wr   = wr_en && (wr_addr == A_CFG);
  assign soft_rst = cfg_wr && (wr_data[CFG_SRST_HI] || wr_data[CFG_SRST_LO]);

  always_ff @(posedge clk) begin
    if (rst)         lsb_first <= 1'b0;
    else if (cfg_wr) lsb_first <= wr_data[CFG_ORDER_HI] || wr_data[CFG_ORDER_LO];
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst)                      chan_q <= '0;
    else if (wr_en && wr_addr == A_CHAN)      chan_q <= wr_data[1:0];
  end

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    localparam logic [ADDR_W-1:0] GA = ADDR_W'(GEN_BASE + g);
    localparam bit KEEP = (GA == ADDR_W'(9)) || (GA == ADDR_W'(10));
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst || (soft_rst && !KEEP))   q <= '0;
      else if (wr_en && wr_addr == GA)  q <= wr_data;
    end
    assign gen_rd[g] = q;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [1:0] SEL = 2'(c + 1);
    logic ch_hit;
    assign ch_hit = (chan_q == 2'd0) || (chan_q == 2'd3) || (chan_q == SEL);
    for (genvar r = 0; r < NCHR; r++) begin : g_reg
      localparam logic [ADDR_W-1:0] CA = ADDR_W'(CH_BASE + r);
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst || soft_rst)                        q <= '0;
        else if (wr_en && ch_hit && wr_addr == CA)  q <= wr_data;
      end
      assign ch_rd[c][r] = q;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CFG) begin
      rd_data[CFG_ORDER_HI] = lsb_first;
      rd_data[CFG_ORDER_LO] = lsb_first;
    end
    if (rd_addr == A_ID)   rd_data = CHIP_ID;
    if (rd_addr == A_CHAN) rd_data = {{(DATA_W-2){1'b0}}, chan_q};
    for (int i = 0; i < NGEN; i++)
      if (rd_addr == ADDR_W'(GEN_BASE + i)) rd_data = gen_rd[i];
    for (int r = 0; r < NCHR; r++)
      if (rd_addr == ADDR_W'(CH_BASE + r))
        rd_data = (chan_q == 2'd2) ? ch_rd[1][r] : ch_rd[0][r];
  end
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave #(
  parameter int         ADDR_W   = 13,
  parameter int         DATA_W   = 8,
  parameter int         SYNC_STG = 2,
  parameter int         GEN_BASE = 8,
  parameter int         NGEN     = 8,
  parameter int         CH_BASE  = 16,
  parameter int         NCHR     = 4,
  parameter logic [7:0] CHIP_ID  = 8'h22
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_csb,
  input  logic spi_sdi,
  output logic spi_sdo,
  output logic spi_sdo_oe
);
  logic              sclk_rise, cs_act, sdi_s, lsb_first, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  spi_pin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .sclk_in(spi_sclk), .csb_in(spi_csb), .sdi_in(spi_sdi),
    .sclk_rise(sclk_rise), .cs_act(cs_act), .sdi_s(sdi_s)
  );

  spi_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .cs_act(cs_act), .sdi(sdi_s),
    .lsb_cfg(lsb_first), .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sdo(spi_sdo), .sdo_oe(spi_sdo_oe)
  );

  spi_reg_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GEN_BASE(GEN_BASE), .NGEN(NGEN),
    .CH_BASE(CH_BASE), .NCHR(NCHR), .CHIP_ID(CHIP_ID)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lsb_first(lsb_first)
  );
endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk #(
  parameter int         ADDR_W  = 13,
  parameter int         DATA_W  = 8,
  parameter logic [7:0] CHIP_ID = 8'h22
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_csb,
  input logic              spi_sdo_oe,
  input logic              cs_act,
  input logic              wr_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data
);
  // R11
  oe_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sdo_oe) |-> !spi_csb);

  // R11
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !spi_sdo_oe);

  // R7
  chip_id_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(1)) |-> (rd_data == DATA_W'(CHIP_ID)));

  // R5
  cfg_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == '0) |-> (rd_data[6] == rd_data[1]));

  // R6
  srst_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == '0) |-> (!rd_data[5] && !rd_data[2]));

  // R3
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R10
  wr_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(cs_act));
endmodule

bind spi_cfg_slave spi_cfg_slave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHIP_ID(CHIP_ID)
) u_chk (
  .clk(clk), .rst(rst), .spi_csb(spi_csb), .spi_sdo_oe(spi_sdo_oe),
  .cs_act(cs_act), .wr_en(wr_en), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/spi_cfg_slave_bench.sv
module spi_cfg_slave_bench;
  localparam int HALF  = 8;
  localparam int LIMIT = 150000;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic spi_sclk = 1'b0, spi_csb = 1'b1, spi_sdi = 1'b0;
  logic spi_sdo, spi_sdo_oe;
  logic lsb_mode = 1'b0;
  int   checks = 0, errors = 0, cyc = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];
  int   mbits = 0;
  logic [7:0] mbyte = '0;

  always #10 clk = ~clk;

  spi_cfg_slave u_spi_cfg_slave (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csb(spi_csb),
    .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run hung, got %0d cycles exp < %0d", cyc, LIMIT);
      summary();
    end
  end

  // monitor: assembles bytes driven by the block and compares with the queue
  always @(posedge spi_sclk) begin
    if (spi_sdo_oe) begin
      mbyte = lsb_mode ? {spi_sdo, mbyte[7:1]} : {mbyte[6:0], spi_sdo};
      mbits++;
      if (mbits == 8) begin
        mbits = 0;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R11 unexpected read byte: got %02h exp none", mbyte);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (mbyte !== e.v) begin
            errors++;
            $display("FAIL %s: got %02h exp %02h", e.tag, mbyte, e.v);
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    spi_sdi = b;
    tick(HALF);
    spi_sclk = 1'b1;
    tick(HALF);
    spi_sclk = 1'b0;
  endtask

  task automatic put_bits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) put_bit(lsb_mode ? w[i] : w[n-1-i]);
  endtask

  task automatic open_frame(input logic rd, input logic [1:0] len, input logic [12:0] a);
    spi_csb = 1'b0;
    tick(HALF);
    put_bits({rd, len, a}, 16);
  endtask

  task automatic close_frame();
    tick(HALF);
    spi_csb = 1'b1;
    tick(4*HALF);
  endtask

  task automatic put_byte(input logic [7:0] d);
    put_bits({8'h00, d}, 8);
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d);
    open_frame(1'b0, 2'b00, a);
    put_byte(d);
    close_frame();
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic rd_frame(input logic [12:0] a, input logic [1:0] len, input int n);
    open_frame(1'b1, len, a);
    for (int i = 0; i < n; i++) put_byte(8'h00);
    close_frame();
  endtask

  task automatic rd1(input logic [12:0] a, input logic [7:0] v, input string tag);
    expect_byte(v, tag);
    rd_frame(a, 2'b00, 1);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(3);
    check_bit("R1 oe after reset", spi_sdo_oe, 1'b0);
    rd1(13'h000, 8'h00, "R1 cfg reset");
    rd1(13'h005, 8'h00, "R1 chan reset");
    rd1(13'h008, 8'h00, "R1 gen reset");
    rd1(13'h012, 8'h00, "R1 chreg reset");

    // R7 chip id and unmapped space
    rd1(13'h001, 8'h22, "R7 chip id");
    wr1(13'h001, 8'h55);
    rd1(13'h001, 8'h22, "R7 id after write");
    wr1(13'h1F00, 8'h77);
    rd1(13'h1F00, 8'h00, "R7 unmapped");

    // R2 R3: one byte then extra clocks that must not write 0x0A
    open_frame(1'b0, 2'b00, 13'h00B);
    put_byte(8'hA5);
    put_byte(8'hFF);
    close_frame();
    rd1(13'h00B, 8'hA5, "R2 single write");
    rd1(13'h00A, 8'h00, "R3 extra byte ignored");

    // R3 two-byte write, three-byte read with decrement; R11 oe during write
    open_frame(1'b0, 2'b01, 13'h00D);
    tick(HALF);
    check_bit("R11 oe low in write", spi_sdo_oe, 1'b0);
    put_byte(8'h11);
    put_byte(8'h22);
    close_frame();
    expect_byte(8'h11, "R3 rd3 b0");
    expect_byte(8'h22, "R3 rd3 b1");
    expect_byte(8'hA5, "R3 rd3 b2");
    open_frame(1'b1, 2'b10, 13'h00D);
    tick(HALF);
    check_bit("R11 oe high in read", spi_sdo_oe, 1'b1);
    for (int i = 0; i < 3; i++) put_byte(8'h00);
    close_frame();
    check_bit("R11 oe drops", spi_sdo_oe, 1'b0);

    // R4 streaming write and read, decrementing
    open_frame(1'b0, 2'b11, 13'h00F);
    put_byte(8'h01); put_byte(8'h02); put_byte(8'h03); put_byte(8'h04);
    close_frame();
    expect_byte(8'h01, "R4 st b0");
    expect_byte(8'h02, "R4 st b1");
    expect_byte(8'h03, "R4 st b2");
    expect_byte(8'h04, "R4 st b3");
    expect_byte(8'hA5, "R4 st b4");
    rd_frame(13'h00F, 2'b11, 5);

    // R9 stall between bytes and discarded partial byte
    open_frame(1'b0, 2'b10, 13'h00A);
    put_byte(8'h9A);
    tick(HALF); spi_csb = 1'b1; tick(5*HALF);
    spi_csb = 1'b0; tick(HALF);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    tick(HALF); spi_csb = 1'b1; tick(5*HALF);
    spi_csb = 1'b0; tick(HALF);
    put_byte(8'h99);
    tick(HALF); spi_csb = 1'b1; tick(5*HALF);
    spi_csb = 1'b0; tick(HALF);
    put_byte(8'h98);
    close_frame();
    expect_byte(8'h9A, "R9 stall b0");
    expect_byte(8'h99, "R9 stall b1");
    expect_byte(8'h98, "R9 stall b2");
    rd_frame(13'h00A, 2'b10, 3);

    // R10 aborted instruction
    spi_csb = 1'b0; tick(HALF);
    put_bits({3'b000, 13'h00E}, 10);
    close_frame();
    rd1(13'h00E, 8'h02, "R10 abort no change");

    // R8 channel routing
    wr1(13'h005, 8'h01); wr1(13'h010, 8'hA1);
    wr1(13'h005, 8'h02); wr1(13'h010, 8'hB2);
    rd1(13'h010, 8'hB2, "R8 chan B read");
    wr1(13'h005, 8'h01);
    rd1(13'h010, 8'hA1, "R8 chan A read");
    wr1(13'h005, 8'h00); wr1(13'h011, 8'hC3);
    rd1(13'h011, 8'hC3, "R8 both A copy");
    wr1(13'h005, 8'h02);
    rd1(13'h011, 8'hC3, "R8 both B copy");
    wr1(13'h005, 8'h03);
    rd1(13'h010, 8'hA1, "R8 sel3 reads A");
    rd1(13'h005, 8'h03, "R8 chan readback");

    // R6 soft reset via bit 5
    wr1(13'h000, 8'h20);
    rd1(13'h000, 8'h00, "R6 cfg after srst");
    rd1(13'h005, 8'h00, "R6 chan cleared");
    rd1(13'h00B, 8'h00, "R6 gen cleared");
    rd1(13'h008, 8'h00, "R6 gen 08 cleared");
    rd1(13'h009, 8'h99, "R6 0x09 kept");
    rd1(13'h00A, 8'h9A, "R6 0x0A kept");
    rd1(13'h010, 8'h00, "R6 chreg cleared");
    wr1(13'h00B, 8'h44);
    wr1(13'h000, 8'h04);
    rd1(13'h00B, 8'h00, "R6 srst via bit2");

    // R5 LSB-first order, increment, mirrors
    wr1(13'h000, 8'h02);
    lsb_mode = 1'b1;
    rd1(13'h000, 8'h42, "R5 mirror readback");
    open_frame(1'b0, 2'b11, 13'h00B);
    put_byte(8'h5A); put_byte(8'h6B);
    close_frame();
    expect_byte(8'h5A, "R5 inc b0");
    expect_byte(8'h6B, "R5 inc b1");
    rd_frame(13'h00B, 2'b01, 2);
    wr1(13'h000, 8'h62);
    rd1(13'h000, 8'h42, "R6 cfg kept in srst");
    rd1(13'h00B, 8'h00, "R6 srst in lsb mode");
    rd1(13'h009, 8'h99, "R6 0x09 kept again");
    wr1(13'h000, 8'h00);
    lsb_mode = 1'b0;
    rd1(13'h000, 8'h00, "R5 back to msb");

    tick(10);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 missing read bytes: got %0d left exp 0", exp_q.size());
    end
    done = 1'b1;
    summary();
  end
endmodule